// File: doc/BRIEF.md
# Saturating Counting Bloom Filter

This block keeps an approximate set of fixed-width keys that can grow and shrink. Each key is mapped to one small saturating counter in each of eight independent memory banks. Adding a key raises those eight counters by one, and deleting it lowers them by one. A query answers "possibly present" only when all eight counters are non-zero. Each bank has its own read port and its own write port, so every hash lookup runs in parallel. The counters live in synchronous memory and not in flip-flops.

A command is transferred on a valid/ready handshake. A query returns its answer one cycle after it is accepted, and a new query may be accepted every cycle. Add and delete are read-modify-write operations. The counters are read in the accept cycle and written back in the cycle after it, and ready stays low during that write-back. The next command therefore always sees the updated array. A clear command, and reset as well, zero the array by walking through every bank address, one address per cycle. A sticky flag records any attempt to lower a counter that was already zero.

Top module: `cbf_filter`

## Requirements
- R1: Reset starts a zeroing pass. Ready stays low for exactly 64 cycles after reset is released, rsp_valid and underflow stay low, and every later query misses until a key is added.
- R2: Bank i (i = 0..7) is indexed by key[6i+5:6i] XOR key[6j+5:6j] with j = (i+3) mod 8. Two keys whose eight indices are equal cannot be told apart.
- R3: An add (cmd_op = 1) raises each of the key's eight counters by one. A query of that key then hits.
- R4: An add leaves a counter that already holds 15 at 15, and does not wrap it.
- R5: A delete (cmd_op = 2) lowers each of the key's eight counters by one. A counter at 0 stays at 0 and sets underflow. Underflow stays high until the next clear.
- R6: A query (cmd_op = 0) gives rsp_valid high in the cycle after acceptance, with rsp_hit high exactly when all eight addressed counters are non-zero. A query changes no counter and keeps ready high.
- R7: After an add or delete is accepted, ready is low for exactly one cycle. A command accepted afterwards sees the written-back values.
- R8: A clear (cmd_op = 3) holds ready low for exactly 64 cycles, zeroes every counter and clears underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 0 query, 1 add, 2 delete, 3 clear |
| cmd_key | input | 48 | Key, eight 6-bit slices |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| rsp_valid | output | 1 | Query answer valid |
| rsp_hit | output | 1 | All eight counters non-zero |
| underflow | output | 1 | Sticky flag for a delete that found a zero counter |

## Verification
The properties assume that cmd_op is stable whenever a command is accepted. They also assume that no command is presented as accepted while ready is low. The bench drives every command only after it has seen ready high at a falling edge, and drops valid at the next falling edge. Keys for the random phase come from a small pool whose slices take only a few values. This forces many keys to share counters, so counters saturate, deletes hit zero, and queries of keys that were never added can still hit. A bench-side counter model checks all of these cases.

// File: rtl/cbf_pkg.sv
package cbf_pkg;

    localparam int DEF_NHASH = 8;
    localparam int DEF_IDX_W = 6;
    localparam int DEF_CNT_W = 4;

    typedef enum logic [1:0] {
        OP_QUERY = 2'd0,
        OP_ADD   = 2'd1,
        OP_DEL   = 2'd2,
        OP_CLEAR = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRBK  = 2'd1,
        ST_SWEEP = 2'd2
    } state_e;

    typedef struct packed {
        logic qry;
        op_e  op;
    } held_cmd_t;

endpackage

// File: rtl/cbf_hash.sv
module cbf_hash #(
    parameter int NHASH = cbf_pkg::DEF_NHASH,
    parameter int IDX_W = cbf_pkg::DEF_IDX_W
) (
    input  logic [NHASH*IDX_W-1:0] key,
    output logic [NHASH*IDX_W-1:0] idx_flat
);
    for (genvar g = 0; g < NHASH; g++) begin : g_fold
        localparam int PARTNER = (g + 3) % NHASH;
        assign idx_flat[g*IDX_W +: IDX_W] =
            key[g*IDX_W +: IDX_W] ^ key[PARTNER*IDX_W +: IDX_W];
    end
endmodule

// File: rtl/cbf_bank.sv
module cbf_bank #(
    parameter int IDX_W = cbf_pkg::DEF_IDX_W,
    parameter int CNT_W = cbf_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_cnt,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CNT_W-1:0] wr_cnt
);
    localparam int DEPTH = 1 << IDX_W;

    logic [CNT_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_cnt;
        if (rd_en) rd_cnt <= mem[rd_idx];
    end
endmodule

// File: rtl/cbf_lane.sv
module cbf_lane
    import cbf_pkg::*;
#(
    parameter int IDX_W = cbf_pkg::DEF_IDX_W,
    parameter int CNT_W = cbf_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             wr_en,
    input  logic             clr,
    input  op_e              upd_op,
    input  logic [IDX_W-1:0] wr_idx,
    output logic [CNT_W-1:0] cur_cnt,
    output logic [CNT_W-1:0] new_cnt,
    output logic             nonzero,
    output logic             at_floor
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [CNT_W-1:0] nxt;

    always_comb begin
        unique case (upd_op)
            OP_ADD:  nxt = (cur_cnt == CMAX) ? cur_cnt : cur_cnt + CNT_W'(1);
            OP_DEL:  nxt = (cur_cnt == '0)   ? cur_cnt : cur_cnt - CNT_W'(1);
            default: nxt = cur_cnt;
        endcase
    end

    assign new_cnt  = clr ? '0 : nxt;
    assign nonzero  = |cur_cnt;
    assign at_floor = (upd_op == OP_DEL) && (cur_cnt == '0);

    cbf_bank #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_mem (
        .clk    (clk),
        .rd_en  (rd_en),
        .rd_idx (rd_idx),
        .rd_cnt (cur_cnt),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_cnt (new_cnt)
    );
endmodule

// File: rtl/cbf_filter.sv
module cbf_filter
    import cbf_pkg::*;
#(
    parameter int NHASH = cbf_pkg::DEF_NHASH,
    parameter int IDX_W = cbf_pkg::DEF_IDX_W,
    parameter int CNT_W = cbf_pkg::DEF_CNT_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmd_valid,
    input  logic [1:0]             cmd_op,
    input  logic [NHASH*IDX_W-1:0] cmd_key,
    output logic                   cmd_ready,
    output logic                   rsp_valid,
    output logic                   rsp_hit,
    output logic                   underflow
);
    localparam int KEY_W = NHASH * IDX_W;

    state_e            state;
    held_cmd_t         held;
    logic [KEY_W-1:0]  idx_now, idx_q;
    logic [IDX_W-1:0]  sweep_idx;
    logic              uflow_q;
    logic              accept, wr_en;
    op_e               op_in;
    logic [NHASH-1:0]  nz_vec, floor_vec;
    logic [NHASH*CNT_W-1:0] rd_flat, wr_flat;

    assign op_in     = op_e'(cmd_op);
    assign cmd_ready = (state == ST_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign wr_en     = (state == ST_WRBK) || (state == ST_SWEEP);

    cbf_hash #(.NHASH(NHASH), .IDX_W(IDX_W)) u_hash (
        .key      (cmd_key),
        .idx_flat (idx_now)
    );

    for (genvar g = 0; g < NHASH; g++) begin : g_lane
        logic [IDX_W-1:0] widx;
        assign widx = (state == ST_SWEEP) ? sweep_idx : idx_q[g*IDX_W +: IDX_W];

        cbf_lane #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_lane (
            .clk      (clk),
            .rd_en    (accept),
            .rd_idx   (idx_now[g*IDX_W +: IDX_W]),
            .wr_en    (wr_en),
            .clr      (state == ST_SWEEP),
            .upd_op   (held.op),
            .wr_idx   (widx),
            .cur_cnt  (rd_flat[g*CNT_W +: CNT_W]),
            .new_cnt  (wr_flat[g*CNT_W +: CNT_W]),
            .nonzero  (nz_vec[g]),
            .at_floor (floor_vec[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_SWEEP;
            sweep_idx <= '0;
            held      <= '{qry: 1'b0, op: OP_QUERY};
            idx_q     <= '0;
            uflow_q   <= 1'b0;
        end else begin
            held.qry <= accept && (op_in == OP_QUERY);
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        held.op <= op_in;
                        idx_q   <= idx_now;
                        if (op_in == OP_ADD || op_in == OP_DEL) begin
                            state <= ST_WRBK;
                        end else if (op_in == OP_CLEAR) begin
                            state     <= ST_SWEEP;
                            sweep_idx <= '0;
                            uflow_q   <= 1'b0;
                        end
                    end
                end
                ST_WRBK: begin
                    state <= ST_IDLE;
                    if (|floor_vec) uflow_q <= 1'b1;
                end
                ST_SWEEP: begin
                    sweep_idx <= sweep_idx + IDX_W'(1);
                    if (&sweep_idx) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign rsp_valid = held.qry;
    assign rsp_hit   = held.qry && (&nz_vec);
    assign underflow = uflow_q;

endmodule

// File: rtl/cbf_filter_chk.sv
module cbf_filter_chk #(
    parameter int NHASH = 8,
    parameter int CNT_W = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   cmd_valid,
    input logic [1:0]             cmd_op,
    input logic                   cmd_ready,
    input logic                   rsp_valid,
    input logic                   underflow,
    input logic                   wr_en,
    input logic [1:0]             held_op,
    input logic [NHASH*CNT_W-1:0] rd_flat,
    input logic [NHASH*CNT_W-1:0] wr_flat
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic acc;
    assign acc = cmd_valid && cmd_ready;

    AST_RSP_FOLLOWS_QUERY: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(acc && cmd_op == 2'd0)); // R6

    AST_WRBK_STALL: assert property (@(posedge clk) disable iff (rst)
        acc && (cmd_op == 2'd1 || cmd_op == 2'd2) |=> !cmd_ready); // R7

    AST_CLEAR_STALL: assert property (@(posedge clk) disable iff (rst)
        acc && cmd_op == 2'd3 |=> !cmd_ready); // R8

    AST_UFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
        underflow && !(acc && cmd_op == 2'd3) |=> underflow); // R5

    for (genvar g = 0; g < NHASH; g++) begin : g_cnt
        AST_ADD_SATURATES: assert property (@(posedge clk) disable iff (rst)
            wr_en && held_op == 2'd1 && rd_flat[g*CNT_W +: CNT_W] == CMAX
            |-> wr_flat[g*CNT_W +: CNT_W] == CMAX); // R4

        AST_DEL_FLOOR: assert property (@(posedge clk) disable iff (rst)
            wr_en && held_op == 2'd2 && rd_flat[g*CNT_W +: CNT_W] == '0
            |-> wr_flat[g*CNT_W +: CNT_W] == '0); // R5

        AST_UFLOW_SETS: assert property (@(posedge clk) disable iff (rst)
            wr_en && held_op == 2'd2 && rd_flat[g*CNT_W +: CNT_W] == '0
            |=> underflow); // R5
    end
endmodule

bind cbf_filter cbf_filter_chk #(.NHASH(NHASH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_ready (cmd_ready),
    .rsp_valid (rsp_valid),
    .underflow (underflow),
    .wr_en     (wr_en),
    .held_op   (held.op),
    .rd_flat   (rd_flat),
    .wr_flat   (wr_flat)
);

// File: tb/cbf_filter_tb.sv
module cbf_filter_tb;
    localparam int NH = 8;
    localparam int IW = 6;
    localparam int DEPTH = 1 << IW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic [47:0]   cmd_key = '0;
    logic          cmd_ready, rsp_valid, rsp_hit, underflow;

    int nchk = 0;
    int nfail = 0;
    int cnt [NH][DEPTH];
    bit exp_uf = 1'b0;

    always #2 clk = ~clk;

    cbf_filter u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_key(cmd_key), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .underflow(underflow)
    );

    function automatic int bidx(logic [47:0] k, int i);
        return int'(k[6*i +: 6] ^ k[6*((i+3)%8) +: 6]);
    endfunction

    function automatic bit exp_hit(logic [47:0] k);
        for (int i = 0; i < NH; i++) if (cnt[i][bidx(k, i)] == 0) return 1'b0;
        return 1'b1;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < NH; i++)
            for (int a = 0; a < DEPTH; a++) cnt[i][a] = 0;
        exp_uf = 1'b0;
    endtask

    task automatic chk(bit ok, string req, int act, int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic issue(logic [1:0] op, logic [47:0] key, string req);
        int lows;
        bit e;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        e = exp_hit(key);
        cmd_valid = 1'b1; cmd_op = op; cmd_key = key;
        @(negedge clk);
        cmd_valid = 1'b0;
        case (op)
            2'd0: begin
                chk(rsp_valid == 1'b1, "R6 rsp_valid", int'(rsp_valid), 1);
                chk(rsp_hit == e, req, int'(rsp_hit), int'(e));
                chk(cmd_ready == 1'b1, "R6 ready after query", int'(cmd_ready), 1);
            end
            2'd1, 2'd2: begin
                chk(cmd_ready == 1'b0, "R7 write-back stall", int'(cmd_ready), 0);
                for (int i = 0; i < NH; i++) begin
                    int a = bidx(key, i);
                    if (op == 2'd1) begin
                        if (cnt[i][a] < 15) cnt[i][a]++;
                    end else begin
                        if (cnt[i][a] == 0) exp_uf = 1'b1;
                        else cnt[i][a]--;
                    end
                end
                @(negedge clk);
                chk(cmd_ready == 1'b1, "R7 single stall cycle", int'(cmd_ready), 1);
            end
            default: begin
                lows = 0;
                while (!cmd_ready) begin lows++; @(negedge clk); end
                chk(lows == DEPTH, "R8 clear sweep length", lows, DEPTH);
                model_clear();
            end
        endcase
        chk(underflow == exp_uf, "R5 underflow flag", int'(underflow), int'(exp_uf));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("%0d/%0d checks passed", nchk - nfail, nchk + 1);
        $finish;
    end

    initial begin
        int lows;
        logic [47:0] pool [6];
        logic [47:0] ks;
        void'($urandom(32'd20240611));
        model_clear();

        // R1: reset state and the zeroing pass
        repeat (3) @(negedge clk);
        chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", int'(rsp_valid), 0);
        chk(underflow == 1'b0, "R1 underflow in reset", int'(underflow), 0);
        chk(cmd_ready == 1'b0, "R1 ready in reset", int'(cmd_ready), 0);
        rst = 1'b0;
        lows = 0;
        while (!cmd_ready) begin lows++; @(negedge clk); end
        chk(lows == DEPTH, "R1 initial sweep length", lows, DEPTH);
        issue(2'd0, {$urandom, $urandom}, "R1 query after reset misses");

        // R2, R3: index folding; all-equal slices alias key zero
        issue(2'd1, 48'h0, "R3 add");
        issue(2'd0, 48'h0, "R3 query hit after add");
        issue(2'd0, {8{6'h2A}}, "R2 aliased key hits");
        issue(2'd0, {{7{6'h2A}}, 6'h15}, "R2 distinct key misses");
        issue(2'd2, 48'h0, "R5 delete");
        issue(2'd0, 48'h0, "R5 query miss after delete");

        // R4: saturation at 15
        ks = {$urandom, $urandom};
        for (int n = 0; n < 17; n++) issue(2'd1, ks, "R4 add");
        for (int n = 0; n < 14; n++) issue(2'd2, ks, "R4 delete");
        issue(2'd0, ks, "R4 saturated counter still set");
        issue(2'd2, ks, "R4 delete");
        issue(2'd0, ks, "R4 counter reached zero");

        // R5: underflow and stickiness
        issue(2'd2, ks, "R5 delete at zero");
        issue(2'd1, ks, "R5 add");
        issue(2'd0, ks, "R5 query after add");

        // R8: clear
        issue(2'd1, 48'h123456789ABC, "R8 add");
        issue(2'd3, 48'h0, "R8 clear");
        issue(2'd0, 48'h123456789ABC, "R8 query miss after clear");
        issue(2'd0, ks, "R8 query miss after clear");

        // random mix over a colliding key pool
        for (int p = 0; p < 6; p++)
            for (int s = 0; s < NH; s++) pool[p][6*s +: 6] = 6'($urandom_range(0, 3));
        for (int n = 0; n < 700; n++) begin
            int r = $urandom_range(0, 99);
            logic [47:0] k = pool[$urandom_range(0, 5)];
            if (r < 40)      issue(2'd0, k, "R6 random query");
            else if (r < 72) issue(2'd1, k, "R3 random add");
            else if (r < 98) issue(2'd2, k, "R5 random delete");
            else             issue(2'd3, k, "R8 random clear");
        end

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule